// File: doc/BRIEF.md
# Mispredict-Driven Speculation Throttle

This block decides whether the memory pipeline may run speculatively or must run conservatively. A 2-bit policy field, taken from a write-only control register, picks one of four policies:
- always speculate;
- always stay conservative;
- one of two periodic policies, which differ only in their step.

In the periodic policies an 8-bit saturating score rises by a fixed step on every branch mispredict and falls by one on every retired conditional branch. The pipeline is held conservative while the top bit of the score is set.

The surrounding core drives a register-write strobe with its data word, a mispredict pulse and a conditional-branch-retire pulse. The core reads back one registered flag, which asks the memory pipeline to stop speculating. The retry and stall actions that this flag triggers in the pipeline belong to other blocks.

Top module: `spec_throttle`

## Requirements
- R1: After reset the policy field is 00, the score is 0 and `conservative_o` is 0.
- R2: With policy 00 (bits [5:4] of the written word), `conservative_o` stays 0 whatever the mispredict and retire inputs do.
- R3: With policy 01, `conservative_o` stays 1 whatever the mispredict and retire inputs do.
- R4: With policy 10, each mispredict cycle adds 4 to the score and each retire cycle subtracts 1. `conservative_o` is 1 exactly when the score is 128 or more (bit 7 set).
- R5: With policy 11, each mispredict cycle adds 8 to the score. Retire and the bit-7 rule work as in R4.
- R6: The score saturates at 255 and never wraps on a mispredict.
- R7: The score saturates at 0 and never wraps on a retire.
- R8: A mispredict and a retire in the same cycle change the score by step minus 1 in one update, with saturation applied to the net result.
- R9: A write loads the policy from bits [5:4] and ignores all other data bits. It also clears the score to 0, and any mispredict or retire in that same cycle is dropped.
- R10: `conservative_o` is registered. It shows the policy and score after the update of the clock edge that sampled the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 64 | Control register write data; policy at [5:4] |
| mispredict_i | input | 1 | Branch mispredict pulse, one per cycle |
| br_retire_i | input | 1 | Conditional branch retire pulse, one per cycle |
| conservative_o | output | 1 | Registered conservative-mode request |

## Verification
The score is internal, so the only place a wrong value can show is `conservative_o`. That flag shows it only when the error moves the score across the 127/128 boundary. A wrong step, a wrapped saturation or a missed clear therefore tends to stay hidden until the score approaches the boundary. It then appears as an early or late toggle of the flag, on the cycle after the edge where the model and the design disagree across bit 7. For this reason the stimulus repeatedly drives the score to both saturation points and back across the boundary, and the bench checks the flag on every cycle.

// File: rtl/spec_throttle_pkg.sv
package spec_throttle_pkg;
  typedef enum logic [1:0] {
    POL_SPEC  = 2'b00,
    POL_CONS  = 2'b01,
    POL_SLOW  = 2'b10,
    POL_FAST  = 2'b11
  } thr_pol_e;

  function automatic logic pol_periodic(thr_pol_e p);
    return p[1];
  endfunction
endpackage

// File: rtl/thr_ctl_reg.sv
module thr_ctl_reg
  import spec_throttle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic [1:0] pol_i,
  output thr_pol_e pol_q_o,
  output thr_pol_e pol_nxt_o
);
  thr_pol_e pol_q;

  assign pol_nxt_o = we_i ? thr_pol_e'(pol_i) : pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_q <= POL_SPEC;
    else         pol_q <= pol_nxt_o;
  end

  assign pol_q_o = pol_q;

  a_r9_pol_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> pol_q == thr_pol_e'($past(pol_i)));
  a_r9_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pol_q));
endmodule

// File: rtl/thr_score.sv
module thr_score #(
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CNT_W-1:0]  cnt_q_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);
  localparam int EXT_W = ((CNT_W > STEP_W) ? CNT_W : STEP_W) + 2;
  localparam logic [EXT_W-1:0] MAX_EXT = EXT_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] up_sum, net_sum;

  always_comb begin
    up_sum  = EXT_W'(cnt_q) + (inc_i ? EXT_W'(step_i) : '0);
    net_sum = up_sum;
    if (dec_i && up_sum != '0) net_sum = up_sum - 1'b1;
    if (net_sum > MAX_EXT) net_sum = MAX_EXT;
    if (clr_i)      cnt_nxt_o = '0;
    else if (en_i)  cnt_nxt_o = net_sum[CNT_W-1:0];
    else            cnt_nxt_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_q_o = cnt_q;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q == {CNT_W{1'b1}} && inc_i) |=> cnt_q == {CNT_W{1'b1}});
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q == '0 && dec_i && !inc_i) |=> cnt_q == '0);
  a_r8_net_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && inc_i && dec_i && step_i != '0 &&
     (EXT_W'(cnt_q) + EXT_W'(step_i)) <= MAX_EXT + 1'b1)
    |=> EXT_W'(cnt_q) == EXT_W'($past(cnt_q)) + EXT_W'($past(step_i)) - 1'b1);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/spec_throttle.sv
module spec_throttle
  import spec_throttle_pkg::*;
#(
  parameter int CTL_W     = 64,
  parameter int POL_LSB   = 4,
  parameter int CNT_W     = 8,
  parameter int STEP_SLOW = 4,
  parameter int STEP_FAST = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             mispredict_i,
  input  logic             br_retire_i,
  output logic             conservative_o
);
  localparam int STEP_MAX = (STEP_FAST > STEP_SLOW) ? STEP_FAST : STEP_SLOW;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);

  thr_pol_e         pol_q, pol_nxt;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              cons_nxt, cons_q;

  logic unused_wdata;
  assign unused_wdata = ^{ctl_wdata_i[CTL_W-1:POL_LSB+2], ctl_wdata_i[POL_LSB-1:0]};

  thr_ctl_reg u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl_we_i),
    .pol_i     (ctl_wdata_i[POL_LSB+1:POL_LSB]),
    .pol_q_o   (pol_q),
    .pol_nxt_o (pol_nxt)
  );

  // step chosen by current policy; unused outside periodic policies
  assign step = (pol_q == POL_FAST) ? STEP_W'(STEP_FAST) : STEP_W'(STEP_SLOW);

  thr_score #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_score (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctl_we_i),
    .en_i      (pol_periodic(pol_q)),
    .inc_i     (mispredict_i),
    .dec_i     (br_retire_i),
    .step_i    (step),
    .cnt_q_o   (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  always_comb begin
    unique case (pol_nxt)
      POL_SPEC: cons_nxt = 1'b0;
      POL_CONS: cons_nxt = 1'b1;
      default:  cons_nxt = cnt_nxt[CNT_W-1];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cons_q <= 1'b0;
    else         cons_q <= cons_nxt;
  end

  assign conservative_o = cons_q;

  a_r2_spec_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_q == POL_SPEC && !ctl_we_i) |=> !conservative_o);
  a_r3_cons_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_q == POL_CONS && !ctl_we_i) |=> conservative_o);
  a_r4_msb_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_periodic(pol_q) |-> conservative_o == cnt_q[CNT_W-1]);
endmodule

// File: tb/spec_throttle_test.sv
module spec_throttle_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [63:0] wd = '0;
  logic        mis = 1'b0;
  logic        ret = 1'b0;
  logic        cons;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  logic [1:0] m_pol = 2'b00;
  bit done = 0;

  always #4 clk = ~clk;

  spec_throttle uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wd),
    .mispredict_i(mis), .br_retire_i(ret), .conservative_o(cons)
  );

  function automatic logic exp_flag(logic [1:0] p, int c);
    if (p == 2'b00) return 1'b0;
    if (p == 2'b01) return 1'b1;
    return c >= 128;
  endfunction

  function automatic int next_cnt(logic [1:0] p, int c, logic i, logic d);
    int n;
    if (!p[1]) return 0;
    n = c + (i ? ((p == 2'b11) ? 8 : 4) : 0) - (d ? 1 : 0);
    if (n > 255) n = 255;
    if (n < 0) n = 0;
    return n;
  endfunction

  task automatic chk(string tag);
    logic e;
    e = exp_flag(m_pol, m_cnt);
    checks++;
    if (cons !== e) begin
      errors++;
      $display("FAIL %s: conservative_o=%b expected %b (pol=%b score=%0d)",
               tag, cons, e, m_pol, m_cnt);
    end
  endtask

  // one cycle: drive at negedge, model at the edge, check after it (R10)
  task automatic cyc(logic w, logic [63:0] d, logic i, logic r, string tag);
    we = w; wd = d; mis = i; ret = r;
    if (w) begin
      m_pol = d[5:4];
      m_cnt = 0;
    end else begin
      m_cnt = next_cnt(m_pol, m_cnt, i, r);
    end
    @(posedge clk);
    #2;
    chk(tag);
    @(negedge clk);
    we = 0; mis = 0; ret = 0;
  endtask

  task automatic wr(logic [1:0] p, string tag);
    logic [63:0] d;
    d = {$urandom(), $urandom()};
    d[5:4] = p;
    cyc(1'b1, d, $urandom_range(0, 1), $urandom_range(0, 1), tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 chk("R1");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset leaves policy 00; mispredicts keep flag low
    for (int k = 0; k < 40; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R1");
    // R2: policy 00 ignores all events
    wr(2'b00, "R9");
    for (int k = 0; k < 100; k++) cyc(1'b0, '0, $urandom_range(0, 1), $urandom_range(0, 1), "R2");
    // R3: policy 01 forced
    wr(2'b01, "R3");
    for (int k = 0; k < 100; k++) cyc(1'b0, '0, $urandom_range(0, 1), $urandom_range(0, 1), "R3");
    // R4: step 4, 32 mispredicts reach 128, one retire drops to 127
    wr(2'b10, "R9");
    for (int k = 0; k < 32; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R4");
    cyc(1'b0, '0, 1'b0, 1'b1, "R4");
    cyc(1'b0, '0, 1'b1, 1'b0, "R4");
    // R6: saturate high, then 127 retires keep 128, 128th drops
    for (int k = 0; k < 40; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R6");
    for (int k = 0; k < 128; k++) cyc(1'b0, '0, 1'b0, 1'b1, "R6");
    // R7: saturate low, then climb back needs full 32 steps
    for (int k = 0; k < 140; k++) cyc(1'b0, '0, 1'b0, 1'b1, "R7");
    for (int k = 0; k < 32; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R7");
    // R8: simultaneous events, net +3 per cycle
    wr(2'b10, "R9");
    for (int k = 0; k < 45; k++) cyc(1'b0, '0, 1'b1, 1'b1, "R8");
    for (int k = 0; k < 50; k++) cyc(1'b0, '0, 1'b1, 1'b1, "R8");
    // R9: rewrite clears score even with same policy and events
    cyc(1'b1, 64'hFFFF_FFFF_FFFF_FFEF, 1'b1, 1'b1, "R9");
    cyc(1'b0, '0, 1'b1, 1'b0, "R9");
    // R5: step 8, 16 mispredicts reach 128
    wr(2'b11, "R5");
    for (int k = 0; k < 16; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R5");
    cyc(1'b0, '0, 1'b0, 1'b1, "R5");
    for (int k = 0; k < 40; k++) cyc(1'b0, '0, 1'b1, 1'b1, "R8");
    // random mix over all policies
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 199) == 0) wr(2'($urandom_range(0, 3)), "R9");
      else cyc(1'b0, '0, $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 60, "R10");
    end
    // mid-run reset returns to R1 state
    rst_n = 1'b0;
    m_pol = 2'b00; m_cnt = 0;
    #2 chk("R1");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, '0, 1'b1, 1'b0, "R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule